// File: doc/BRIEF.md
# Timer Interrupt Routing Logic

This block sits between a bank of comparator timers and an interrupt controller and decides, per timer, how a comparator match reaches software. A match can become a message write (a 32-bit address and 32-bit data word), a one-cycle edge pulse on a numbered controller pin, or a level assertion on a pin that stays held until software clears the timer's status bit. The block owns each timer's routing configuration word and message register. It checks a requested pin against the timer's allowed-pin mask, and it issues the matching deassert when a held level is released.

Every match, and every release caused by a status clear or a configuration change, is recorded as pending per timer. A small state machine then serves them one at a time. Its states are IDLE, FIRE and RELEASE. The transitions are: IDLE→RELEASE when any release is pending; IDLE→FIRE when only fire requests are pending; FIRE→IDLE and RELEASE→IDLE unconditionally. When it leaves IDLE it picks the lowest-numbered timer with a pending release, and if there is none, the lowest-numbered timer with a pending fire. Requests are visible on the output ports while the machine is in FIRE or RELEASE.

Top module: `tmr_irq_router`

## Requirements
- R1: After reset no request output is valid, all status bits are 0, and every timer's configuration reads back as allowed-pin mask in bits 63:32 and 32'h0000_8000 in bits 31:0 (message-capable bit 15 set).
- R2: A strobe sampled at clock edge E0 yields its request during the cycle after edge E1, and none before. The machine spends one cycle in FIRE or RELEASE and then returns to IDLE. Pending releases are served before pending fires, and lower timer indices first.
- R3: While the legacy-route input is 1, a match of timer 0 pulses pin 2 and a match of timer 1 pulses pin 8. This holds whatever their trigger, pin and message settings are, and their status bit stays 0.
- R4: A match uses message delivery only when configuration bits 15 (capable) and 14 (message enable) are both 1. The message address is bits 63:32 of the timer's message register and the data is bits 31:0.
- R5: Otherwise the pin is configuration bits 13:9, and with bit 1 equal to 0 (edge) a match gives a single pulse on that pin.
- R6: With bit 1 equal to 1 (level), a match asserts the pin and sets the timer's status bit. Further matches of that timer produce nothing while the bit is set.
- R7: A match produces nothing when the interrupt-enable bit 2 is 0, or when the route is a pin and bits 13:9 are 0.
- R8: A configuration write requesting a nonzero pin whose bit is 0 in the allowed-pin mask stores 0 in bits 13:9.
- R9: Only bits 1, 2, 13:9 and 14 are writable. Bit 8 (forced 32-bit mode) reads 0, bit 15 keeps its reset value, and bits 63:32 always read as the allowed-pin mask.
- R10: A clear strobe for a timer whose status bit is set clears the bit and deasserts the pin that the timer currently routes to. A clear strobe for a timer whose status bit is 0 produces nothing.
- R11: When a status bit is set, a configuration write that disables the interrupt, selects edge or message delivery, or changes the pin clears the bit and deasserts the old pin. A write that leaves the level route unchanged keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_en | input | 1 | Global legacy-route bit |
| tmr_match | input | NUM_TIMERS | Per-timer comparator match strobes |
| isr_clr | input | NUM_TIMERS | Per-timer status clear strobes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | clog2(NUM_TIMERS) | Timer addressed by the configuration write |
| cfg_wdata | input | 32 | Low configuration word to write |
| msg_we | input | 1 | Message register write strobe |
| msg_idx | input | clog2(NUM_TIMERS) | Timer addressed by the message write |
| msg_wdata | input | 64 | Message register value (address high, data low) |
| rd_idx | input | clog2(NUM_TIMERS) | Timer whose configuration is read back |
| rd_cfg | output | 64 | Configuration of the timer at rd_idx |
| isr_status | output | NUM_TIMERS | Level status bits |
| pulse_vld | output | 1 | Edge pulse request |
| pulse_pin | output | 5 | Pin to pulse |
| assert_vld | output | 1 | Level assert request |
| assert_pin | output | 5 | Pin to assert |
| deassert_vld | output | 1 | Level deassert request |
| deassert_pin | output | 5 | Pin to deassert |
| msg_vld | output | 1 | Message write request |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench builds the block with four timers and an allowed-pin mask of 32'h80F0_0106, which opens pins 1, 2, 8, 20 to 23 and 31. For every timer it sweeps all 32 route codes, so the accept and reject paths of pin validation and both ends of the pin range are exercised, and each accepted edge route is then fired. Four timers cover both legacy slots and two ordinary slots, which is enough to check that legacy routing leaves the other timers alone and that simultaneous strobes are served in the stated order.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    localparam int unsigned PIN_W     = 5;
    localparam int unsigned CB_LEVEL  = 1;
    localparam int unsigned CB_INTEN  = 2;
    localparam int unsigned CB_F32    = 8;
    localparam int unsigned CB_RT_LO  = 9;
    localparam int unsigned CB_RT_HI  = 13;
    localparam int unsigned CB_MSGEN  = 14;
    localparam int unsigned CB_MSGCAP = 15;

    // bits 1, 2, 13:9 and 14 may be written
    localparam logic [31:0] CFG_WR_MASK = 32'h0000_7E06;

    localparam logic [PIN_W-1:0] LEG_PIN_T0 = 5'd2;
    localparam logic [PIN_W-1:0] LEG_PIN_T1 = 5'd8;

    typedef enum logic [1:0] {
        RK_NONE  = 2'd0,
        RK_PULSE = 2'd1,
        RK_LEVEL = 2'd2,
        RK_MSG   = 2'd3
    } rkind_e;

    typedef struct packed {
        rkind_e           kind;
        logic [PIN_W-1:0] pin;
    } route_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FIRE    = 2'd1,
        ST_RELEASE = 2'd2
    } seq_state_e;

    // Delivery path of one timer, without regard to its enable or status.
    function automatic route_t route_of(input logic [31:0] c,
                                        input logic        legacy,
                                        input int unsigned idx);
        route_t r;
        r.kind = RK_NONE;
        r.pin  = '0;
        if (legacy && (idx < 2)) begin
            r.kind = RK_PULSE;
            r.pin  = (idx == 0) ? LEG_PIN_T0 : LEG_PIN_T1;
        end else if (c[CB_MSGCAP] && c[CB_MSGEN]) begin
            r.kind = RK_MSG;
        end else if (c[CB_RT_HI:CB_RT_LO] != '0) begin
            r.kind = c[CB_LEVEL] ? RK_LEVEL : RK_PULSE;
            r.pin  = c[CB_RT_HI:CB_RT_LO];
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 3
) (
    input  logic [N-1:0]  rel_req,
    input  logic [N-1:0]  fire_req,
    output logic          any_req,
    output logic          pick_rel,
    output logic [IW-1:0] pick_idx
);

    logic [N-1:0] pool;

    always_comb begin
        any_req  = (|rel_req) | (|fire_req);
        pick_rel = |rel_req;
        pool     = pick_rel ? rel_req : fire_req;
        pick_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pool[i]) pick_idx = IW'(i);
        end
    end

endmodule

// File: rtl/tmr_irq_slot.sv
module tmr_irq_slot
    import tmr_irq_pkg::*;
#(
    parameter int unsigned IDX        = 0,
    parameter logic [31:0] ALLOW_MASK = 32'h00F0_0000,
    parameter logic        MSG_CAP    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             legacy_en,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    input  logic             msg_we,
    input  logic [63:0]      msg_wdata,
    input  logic             match,
    input  logic             isr_clr,
    input  logic             grant_fire,
    input  logic             grant_rel,
    output logic [31:0]      cfg_lo,
    output logic [63:0]      msg_q,
    output route_t           act,
    output logic             status_q,
    output logic             fire_pend,
    output logic             rel_pend,
    output logic [PIN_W-1:0] rel_pin
);

    localparam logic [31:0] CFG_RST = {16'h0, MSG_CAP, 15'h0};

    logic [31:0] cfg_q;
    logic [31:0] cfg_new;
    route_t      cur_rt;
    route_t      new_rt;
    logic        cfg_rel;
    logic        clr_rel;

    always_comb begin
        cfg_new = (cfg_q & ~CFG_WR_MASK) | (cfg_wdata & CFG_WR_MASK);
        if ((cfg_new[CB_RT_HI:CB_RT_LO] != '0) &&
            !ALLOW_MASK[cfg_new[CB_RT_HI:CB_RT_LO]]) begin
            cfg_new[CB_RT_HI:CB_RT_LO] = '0;
        end
        cur_rt = route_of(cfg_q, legacy_en, IDX);
        new_rt = route_of(cfg_new, legacy_en, IDX);
        if (!cfg_q[CB_INTEN] || status_q) begin
            act.kind = RK_NONE;
            act.pin  = '0;
        end else begin
            act = cur_rt;
        end
        cfg_rel = cfg_we && status_q &&
                  (!cfg_new[CB_INTEN] || (new_rt.kind != RK_LEVEL) ||
                   (new_rt.pin != cur_rt.pin));
        clr_rel = isr_clr && status_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= CFG_RST;
            msg_q     <= '0;
            status_q  <= 1'b0;
            fire_pend <= 1'b0;
            rel_pend  <= 1'b0;
            rel_pin   <= '0;
        end else begin
            if (cfg_we) cfg_q <= cfg_new;
            if (msg_we) msg_q <= msg_wdata;

            if (match)           fire_pend <= 1'b1;
            else if (grant_fire) fire_pend <= 1'b0;

            if (cfg_rel || clr_rel)                       status_q <= 1'b0;
            else if (grant_fire && act.kind == RK_LEVEL)  status_q <= 1'b1;

            if (cfg_rel || clr_rel) begin
                rel_pend <= 1'b1;
                rel_pin  <= cur_rt.pin;
            end else if (grant_rel) begin
                rel_pend <= 1'b0;
            end
        end
    end

    assign cfg_lo = cfg_q;

    AST_ROUTE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[CB_RT_HI:CB_RT_LO] != '0) |-> ALLOW_MASK[cfg_q[CB_RT_HI:CB_RT_LO]]); // R8

    AST_LEVEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_fire && act.kind == RK_LEVEL && !isr_clr && !cfg_we) |=> status_q); // R6

    AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_clr && status_q) |=> (!status_q && rel_pend)); // R10

    AST_CFG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && status_q && !cfg_wdata[CB_INTEN]) |=> (!status_q && rel_pend)); // R11

endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
    import tmr_irq_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 8,
    parameter logic [31:0] ALLOW_MASK = 32'h00F0_0000,
    parameter logic        MSG_CAP    = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          legacy_en,
    input  logic [NUM_TIMERS-1:0]         tmr_match,
    input  logic [NUM_TIMERS-1:0]         isr_clr,
    input  logic                          cfg_we,
    input  logic [$clog2(NUM_TIMERS)-1:0] cfg_idx,
    input  logic [31:0]                   cfg_wdata,
    input  logic                          msg_we,
    input  logic [$clog2(NUM_TIMERS)-1:0] msg_idx,
    input  logic [63:0]                   msg_wdata,
    input  logic [$clog2(NUM_TIMERS)-1:0] rd_idx,
    output logic [63:0]                   rd_cfg,
    output logic [NUM_TIMERS-1:0]         isr_status,
    output logic                          pulse_vld,
    output logic [4:0]                    pulse_pin,
    output logic                          assert_vld,
    output logic [4:0]                    assert_pin,
    output logic                          deassert_vld,
    output logic [4:0]                    deassert_pin,
    output logic                          msg_vld,
    output logic [31:0]                   msg_addr,
    output logic [31:0]                   msg_data
);

    localparam int unsigned IW = $clog2(NUM_TIMERS);

    seq_state_e       state_q;
    logic [IW-1:0]    sel_q;

    route_t           act_a  [NUM_TIMERS];
    logic [31:0]      cfg_a  [NUM_TIMERS];
    logic [63:0]      msg_a  [NUM_TIMERS];
    logic [PIN_W-1:0] rpin_a [NUM_TIMERS];
    logic [NUM_TIMERS-1:0] fpend;
    logic [NUM_TIMERS-1:0] rpend;
    logic [NUM_TIMERS-1:0] gfire;
    logic [NUM_TIMERS-1:0] grel;

    logic          any_req;
    logic          pick_rel;
    logic [IW-1:0] pick_idx;

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_slot
        assign gfire[i] = (state_q == ST_FIRE)    && (sel_q == IW'(i));
        assign grel[i]  = (state_q == ST_RELEASE) && (sel_q == IW'(i));

        tmr_irq_slot #(
            .IDX        (i),
            .ALLOW_MASK (ALLOW_MASK),
            .MSG_CAP    (MSG_CAP)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .legacy_en  (legacy_en),
            .cfg_we     (cfg_we && (cfg_idx == IW'(i))),
            .cfg_wdata  (cfg_wdata),
            .msg_we     (msg_we && (msg_idx == IW'(i))),
            .msg_wdata  (msg_wdata),
            .match      (tmr_match[i]),
            .isr_clr    (isr_clr[i]),
            .grant_fire (gfire[i]),
            .grant_rel  (grel[i]),
            .cfg_lo     (cfg_a[i]),
            .msg_q      (msg_a[i]),
            .act        (act_a[i]),
            .status_q   (isr_status[i]),
            .fire_pend  (fpend[i]),
            .rel_pend   (rpend[i]),
            .rel_pin    (rpin_a[i])
        );
    end

    tmr_irq_arb #(
        .N  (NUM_TIMERS),
        .IW (IW)
    ) u_arb (
        .rel_req  (rpend),
        .fire_req (fpend),
        .any_req  (any_req),
        .pick_rel (pick_rel),
        .pick_idx (pick_idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (any_req) begin
                        state_q <= pick_rel ? ST_RELEASE : ST_FIRE;
                        sel_q   <= pick_idx;
                    end
                end
                ST_FIRE:    state_q <= ST_IDLE;
                ST_RELEASE: state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    route_t      sel_act;
    logic [63:0] sel_msg;

    // outputs
    always_comb begin
        sel_act      = act_a[sel_q];
        sel_msg      = msg_a[sel_q];
        pulse_vld    = 1'b0;
        pulse_pin    = '0;
        assert_vld   = 1'b0;
        assert_pin   = '0;
        deassert_vld = 1'b0;
        deassert_pin = '0;
        msg_vld      = 1'b0;
        msg_addr     = '0;
        msg_data     = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FIRE: begin
                unique case (sel_act.kind)
                    RK_PULSE: begin
                        pulse_vld = 1'b1;
                        pulse_pin = sel_act.pin;
                    end
                    RK_LEVEL: begin
                        assert_vld = 1'b1;
                        assert_pin = sel_act.pin;
                    end
                    RK_MSG: begin
                        msg_vld  = 1'b1;
                        msg_addr = sel_msg[63:32];
                        msg_data = sel_msg[31:0];
                    end
                    RK_NONE: ;
                    default: ;
                endcase
            end
            ST_RELEASE: begin
                deassert_vld = 1'b1;
                deassert_pin = rpin_a[sel_q];
            end
            default: ;
        endcase
    end

    assign rd_cfg = {ALLOW_MASK, cfg_a[rd_idx]};

    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pulse_vld, assert_vld, deassert_vld, msg_vld})); // R2

    AST_STATE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q == ST_IDLE)); // R2

    AST_LEGACY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_en && pulse_vld && (int'(sel_q) < 2)) |->
        ((pulse_pin == LEG_PIN_T0) || (pulse_pin == LEG_PIN_T1))); // R3

endmodule

// File: tb/sim_tmr_irq_router.sv
module sim_tmr_irq_router;

    localparam int unsigned NT    = 4;
    localparam logic [31:0] ALLOW = 32'h80F0_0106;
    localparam logic [31:0] B_LVL = 32'h2, B_EN = 32'h4, B_F32 = 32'h100;
    localparam logic [31:0] B_MEN = 32'h4000, B_MCAP = 32'h8000;
    // expected request kinds
    localparam int K_NONE = 0, K_PULSE = 1, K_ASSERT = 2, K_DEASSERT = 3, K_MSG = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic legacy_en = 1'b0;
    logic [NT-1:0] tmr_match = '0, isr_clr = '0;
    logic cfg_we = 1'b0, msg_we = 1'b0;
    logic [1:0] cfg_idx = '0, msg_idx = '0, rd_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [63:0] msg_wdata = '0;
    logic [63:0] rd_cfg;
    logic [NT-1:0] isr_status;
    logic pulse_vld, assert_vld, deassert_vld, msg_vld;
    logic [4:0] pulse_pin, assert_pin, deassert_pin;
    logic [31:0] msg_addr, msg_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tmr_irq_router #(.NUM_TIMERS(NT), .ALLOW_MASK(ALLOW), .MSG_CAP(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en), .tmr_match(tmr_match),
        .isr_clr(isr_clr), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .msg_we(msg_we), .msg_idx(msg_idx), .msg_wdata(msg_wdata), .rd_idx(rd_idx),
        .rd_cfg(rd_cfg), .isr_status(isr_status), .pulse_vld(pulse_vld),
        .pulse_pin(pulse_pin), .assert_vld(assert_vld), .assert_pin(assert_pin),
        .deassert_vld(deassert_vld), .deassert_pin(deassert_pin), .msg_vld(msg_vld),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic int seen_kind();
        int c;
        int k;
        c = int'(pulse_vld) + int'(assert_vld) + int'(deassert_vld) + int'(msg_vld);
        k = K_NONE;
        if (pulse_vld) k = K_PULSE;
        if (assert_vld) k = K_ASSERT;
        if (deassert_vld) k = K_DEASSERT;
        if (msg_vld) k = K_MSG;
        if (c > 1) k = 9;
        return k;
    endfunction

    // Called right after the strobe-dropping negedge: samples one cycle later.
    task automatic observe(input string req, input int ek, input int epin,
                           input logic [31:0] ea, input logic [31:0] ed);
        @(negedge clk);
        chk(req, 64'(seen_kind()), 64'(ek));
        if (ek == K_PULSE)    chk(req, 64'(pulse_pin), 64'(epin));
        if (ek == K_ASSERT)   chk(req, 64'(assert_pin), 64'(epin));
        if (ek == K_DEASSERT) chk(req, 64'(deassert_pin), 64'(epin));
        if (ek == K_MSG) begin
            chk(req, 64'(msg_addr), 64'(ea));
            chk(req, 64'(msg_data), 64'(ed));
        end
        @(negedge clk);
    endtask

    task automatic strobe(input logic [NT-1:0] m, input logic [NT-1:0] c);
        @(negedge clk);
        tmr_match = m;
        isr_clr = c;
        @(negedge clk);
        tmr_match = '0;
        isr_clr = '0;
    endtask

    task automatic wr_cfg(input int i, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_idx = 2'(i);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_msg(input int i, input logic [63:0] d);
        @(negedge clk);
        msg_we = 1'b1;
        msg_idx = 2'(i);
        msg_wdata = d;
        @(negedge clk);
        msg_we = 1'b0;
    endtask

    task automatic rd(input int i, output logic [63:0] v);
        rd_idx = 2'(i);
        #1;
        v = rd_cfg;
    endtask

    function automatic logic [31:0] rt(input int p);
        return 32'(p) << 9;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 outputs", 64'(seen_kind()), 64'(K_NONE));
        chk("R1 status", 64'(isr_status), 64'h0);
        for (int i = 0; i < NT; i++) begin
            rd(i, v);
            chk("R1 cfg", v, {ALLOW, 32'h0000_8000});
        end

        // R5 R7 R8: sweep of every route code on every timer
        for (int i = 0; i < NT; i++) begin
            for (int p = 0; p < 32; p++) begin
                int ep;
                ep = (p != 0 && ALLOW[p]) ? p : 0;
                wr_cfg(i, B_EN | rt(p));
                rd(i, v);
                chk("R8 route field", 64'(v[13:9]), 64'(ep));
                strobe(NT'(1) << i, '0);
                observe(ep == 0 ? "R7 pin zero" : "R5 edge pulse",
                        ep == 0 ? K_NONE : K_PULSE, ep, 0, 0);
            end
        end

        // R9: write protection
        wr_cfg(0, 32'hFFFF_FFFF & ~32'h3E00 | rt(20));
        rd(0, v);
        chk("R9 all ones", v, {ALLOW, 32'h0000_E806});
        wr_cfg(0, 32'h0);
        rd(0, v);
        chk("R9 bit15 kept", v, {ALLOW, 32'h0000_8000});
        wr_cfg(0, B_F32 | B_EN | rt(20));
        rd(0, v);
        chk("R9 bit8 dropped", v, {ALLOW, 32'h0000_A804});

        // R7: interrupt disabled
        wr_cfg(1, rt(20));
        strobe(4'b0010, '0);
        observe("R7 disabled", K_NONE, 0, 0, 0);

        // R6 R10: level, hold, clear
        wr_cfg(2, B_EN | B_LVL | rt(21));
        strobe(4'b0100, '0);
        observe("R6 assert", K_ASSERT, 21, 0, 0);
        chk("R6 status set", 64'(isr_status), 64'h4);
        strobe(4'b0100, '0);
        observe("R6 held match", K_NONE, 0, 0, 0);
        strobe('0, 4'b0100);
        observe("R10 clear deassert", K_DEASSERT, 21, 0, 0);
        chk("R10 status cleared", 64'(isr_status), 64'h0);
        strobe('0, 4'b0100);
        observe("R10 clear idle", K_NONE, 0, 0, 0);

        // R11: configuration driven release
        strobe(4'b0100, '0);
        observe("R6 reassert", K_ASSERT, 21, 0, 0);
        wr_cfg(2, B_EN | B_LVL | rt(21));
        observe("R11 same cfg", K_NONE, 0, 0, 0);
        chk("R11 status kept", 64'(isr_status), 64'h4);
        wr_cfg(2, B_EN | B_LVL | rt(22));
        observe("R11 pin change", K_DEASSERT, 21, 0, 0);
        chk("R11 status after pin", 64'(isr_status), 64'h0);
        strobe(4'b0100, '0);
        observe("R11 new pin", K_ASSERT, 22, 0, 0);
        wr_cfg(2, B_LVL | rt(22));
        observe("R11 disable", K_DEASSERT, 22, 0, 0);
        wr_cfg(2, B_EN | B_LVL | rt(22));
        strobe(4'b0100, '0);
        observe("R11 rearm", K_ASSERT, 22, 0, 0);
        wr_cfg(2, B_EN | rt(22));
        observe("R11 to edge", K_DEASSERT, 22, 0, 0);
        wr_cfg(2, B_EN | B_LVL | rt(22));
        strobe(4'b0100, '0);
        observe("R11 rearm2", K_ASSERT, 22, 0, 0);
        wr_cfg(2, B_EN | B_LVL | B_MEN | rt(22));
        observe("R11 to message", K_DEASSERT, 22, 0, 0);
        chk("R11 status final", 64'(isr_status), 64'h0);

        // R4: message delivery
        wr_msg(3, 64'hFEE0_1000_0000_0041);
        wr_cfg(3, B_EN | B_MEN | B_LVL | rt(20));
        strobe(4'b1000, '0);
        observe("R4 message", K_MSG, 0, 32'hFEE0_1000, 32'h0000_0041);
        chk("R4 no status", 64'(isr_status), 64'h0);
        wr_cfg(3, B_EN | rt(20));
        strobe(4'b1000, '0);
        observe("R4 enable off", K_PULSE, 20, 0, 0);

        // R3: legacy routing
        legacy_en = 1'b1;
        wr_cfg(0, B_EN | B_LVL | B_MEN | rt(20));
        strobe(4'b0001, '0);
        observe("R3 timer0", K_PULSE, 2, 0, 0);
        chk("R3 no status", 64'(isr_status), 64'h0);
        wr_cfg(1, B_EN | B_LVL | rt(21));
        strobe(4'b0010, '0);
        observe("R3 timer1", K_PULSE, 8, 0, 0);
        wr_cfg(2, B_EN | rt(23));
        strobe(4'b0100, '0);
        observe("R3 timer2 own pin", K_PULSE, 23, 0, 0);
        wr_cfg(0, B_LVL | rt(20));
        strobe(4'b0001, '0);
        observe("R7 legacy disabled", K_NONE, 0, 0, 0);
        legacy_en = 1'b0;

        // R2: latency and ordering
        wr_cfg(1, B_EN | rt(21));
        wr_cfg(3, B_EN | rt(23));
        @(negedge clk);
        tmr_match = 4'b1010;
        @(negedge clk);
        tmr_match = '0;
        chk("R2 not early", 64'(seen_kind()), 64'(K_NONE));
        observe("R2 first low index", K_PULSE, 21, 0, 0);
        observe("R2 second", K_PULSE, 23, 0, 0);
        wr_cfg(2, B_EN | B_LVL | rt(22));
        wr_cfg(0, B_EN | rt(20));
        strobe(4'b0100, '0);
        observe("R2 level setup", K_ASSERT, 22, 0, 0);
        strobe(4'b0001, 4'b0100);
        observe("R2 release first", K_DEASSERT, 22, 0, 0);
        observe("R2 fire after", K_PULSE, 20, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule